// File: doc/BRIEF.md
# Periodic Signal Cycle Meter

The block watches one periodic digital input. It times that input against the free-running system clock. After synchronising the input and finding its edges, it counts how many clock cycles the input spends high and how many it spends low. The rising edge that ends a low phase closes a full cycle, and at that edge both counts are captured together.

From the captured pair the block derives three more results: the period, the frequency in hertz and the duty cycle in whole percent. The two quotients come from an iterative shift-subtract divider, so no wide single-cycle division sits in the logic. When the five results are ready, they are published together into output registers and marked with a one-cycle strobe.

A timeout watches for a signal that has stopped or is stuck at one level. When it expires, the results are cleared, a flag is raised and the block goes back to waiting for a first rising edge.

Top module: `cycle_meter`

## Requirements
- R1: While reset is high and in the first cycle after it, every result output reads zero, and `result_valid` and `no_signal` are low.
- R2: `high_cycles` and `low_cycles` give the number of clock cycles the input was high and low in the most recent complete cycle. A cycle runs from one rising edge to the next, after a synchroniser of `SYNC_STAGES` flops. Measurement starts at the first rising edge after reset or after a timeout, so a partial first cycle is never reported.
- R3: The high, low and period counts saturate at 2^`CNT_W`-1 instead of wrapping. `period_cycles` is the saturating sum of the high and low counts.
- R4: `freq_hz` equals floor(`CLK_HZ` / `period_cycles`).
- R5: `duty_pct` equals min(100, floor(`high_cycles` × 100 / `period_cycles`)), as an unsigned binary number.
- R6: `result_valid` is high for exactly one cycle, and only in the first cycle in which all five result outputs show a new set. Between strobes the result outputs hold their values unless a timeout clears them.
- R7: A cycle that closes while a division is still in flight is dropped. Every published set comes from one single cycle, so `period_cycles` always equals the saturating sum of the published high and low counts.
- R8: For a nonzero `timeout_limit`, after `timeout_limit` consecutive clock cycles with no edge on the synchronised input, the following happens. All result outputs read zero, `no_signal` goes high, and measurement restarts from waiting for a rising edge. `no_signal` falls at the next published result.
- R9: When `timeout_limit` is zero, the timeout is disabled. `no_signal` never rises, and the last results are held however long the input stays still.
- R10: If the timeout expires in the same cycle as a division completes, the timeout wins. That result is not published, and `result_valid` is never high together with `no_signal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the measurement time base |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous periodic input to be measured |
| timeout_limit | input | CNT_W | Number of edge-free cycles before the signal is declared absent; 0 disables the timeout |
| high_cycles | output | CNT_W | High-phase length of the last measured cycle, in clock cycles |
| low_cycles | output | CNT_W | Low-phase length of the last measured cycle, in clock cycles |
| period_cycles | output | CNT_W | Saturating sum of the high and low lengths |
| freq_hz | output | FREQ_W | CLK_HZ divided by the period |
| duty_pct | output | 7 | High share of the period in percent, 0 to 100 |
| result_valid | output | 1 | One-cycle strobe marking a freshly published set |
| no_signal | output | 1 | Set when the timeout expires, cleared by the next publication |

## Verification
Two events can land in the same clock cycle: the timeout expiring and the divider finishing a result. To provoke this, the bench drives a short burst of edges that closes one cycle and then leaves the input low. It repeats the burst while sweeping `timeout_limit` across a range wide enough to cover the divider latency, so in some trial the expiry and the completion coincide. Each trial is judged in two ways. A strobe must never be seen while `no_signal` is high. After the input goes quiet, every trial must end with zeroed results and the flag raised.

// File: rtl/cm_pkg.sv
package cm_pkg;

  // Measurement sequencing: wait for a first rising edge, then alternate.
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;

  localparam int DUTY_W    = 7;
  localparam int DUTY_FULL = 100;
  // Extra bits needed to hold a count multiplied by DUTY_FULL.
  localparam int DUTY_GROW = 7;

endpackage

// File: rtl/cm_edge_sync.sv
module cm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_async,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], sig_async};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
  assign fall = ~chain[STAGES-1] & last;

endmodule

// File: rtl/cm_phase_timer.sv
module cm_phase_timer
  import cm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             fall,
  input  logic [CNT_W-1:0] limit,
  output logic             capture,
  output logic [CNT_W-1:0] cap_high,
  output logic [CNT_W-1:0] cap_low,
  output logic             expire
);

  phase_t           phase;
  logic [CNT_W-1:0] hi_cnt, lo_cnt, quiet_cnt;
  logic             expired;
  logic             any_edge;
  logic             fire;
  logic [CNT_W:0]   quiet_next;

  assign any_edge   = rise | fall;
  assign quiet_next = {1'b0, quiet_cnt} + 1'b1;
  assign fire       = !any_edge && !expired && (limit != '0) &&
                      (quiet_next >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_WAIT;
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      quiet_cnt <= '0;
      expired   <= 1'b0;
      capture   <= 1'b0;
      expire    <= 1'b0;
      cap_high  <= '0;
      cap_low   <= '0;
    end else begin
      capture <= 1'b0;
      expire  <= 1'b0;

      if (any_edge) begin
        quiet_cnt <= '0;
        expired   <= 1'b0;
      end else if (!(&quiet_cnt)) begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end

      if (fire) begin
        expire  <= 1'b1;
        expired <= 1'b1;
        phase   <= PH_WAIT;
        hi_cnt  <= '0;
        lo_cnt  <= '0;
      end else begin
        unique case (phase)
          PH_WAIT: begin
            if (rise) begin
              phase  <= PH_HIGH;
              hi_cnt <= CNT_W'(1);
            end
          end
          PH_HIGH: begin
            if (fall) begin
              phase  <= PH_LOW;
              lo_cnt <= CNT_W'(1);
            end else if (!(&hi_cnt)) begin
              hi_cnt <= hi_cnt + 1'b1;
            end
          end
          PH_LOW: begin
            if (rise) begin
              capture  <= 1'b1;
              cap_high <= hi_cnt;
              cap_low  <= lo_cnt;
              phase    <= PH_HIGH;
              hi_cnt   <= CNT_W'(1);
            end else if (!(&lo_cnt)) begin
              lo_cnt <= lo_cnt + 1'b1;
            end
          end
          default: phase <= PH_WAIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/cm_divider.sv
module cm_divider #(
  parameter int W = 39
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);

  localparam int STEP_W = $clog2(W + 1);

  logic [W-1:0]      rem, den;
  logic [STEP_W-1:0] steps;
  logic [W:0]        trial;
  logic              take;

  assign trial = {rem, quotient[W-1]};
  assign take  = trial >= {1'b0, den};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem      <= '0;
      den      <= '0;
      quotient <= '0;
      steps    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          rem      <= '0;
          den      <= divisor;
          quotient <= dividend;
          steps    <= STEP_W'(W);
          busy     <= 1'b1;
        end
      end else begin
        rem      <= take ? W'(trial - {1'b0, den}) : trial[W-1:0];
        quotient <= {quotient[W-2:0], take};
        steps    <= steps - 1'b1;
        if (steps == STEP_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cycle_meter.sv
module cycle_meter
  import cm_pkg::*;
#(
  parameter  int CNT_W       = 32,
  parameter  int CLK_HZ      = 125_000_000,
  parameter  int SYNC_STAGES = 2,
  localparam int FREQ_W      = $clog2(CLK_HZ + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_in,
  input  logic [CNT_W-1:0]  timeout_limit,
  output logic [CNT_W-1:0]  high_cycles,
  output logic [CNT_W-1:0]  low_cycles,
  output logic [CNT_W-1:0]  period_cycles,
  output logic [FREQ_W-1:0] freq_hz,
  output logic [DUTY_W-1:0] duty_pct,
  output logic              result_valid,
  output logic              no_signal
);

  localparam int DIV_W = (CNT_W + DUTY_GROW > FREQ_W) ? CNT_W + DUTY_GROW : FREQ_W;
  localparam int LANES = 2;   // lane 0: frequency, lane 1: duty
  localparam logic [DIV_W-1:0] FREQ_CAP = DIV_W'((64'd1 << FREQ_W) - 1);
  localparam logic [DIV_W-1:0] DUTY_CAP = DIV_W'(DUTY_FULL);

  logic             rise, fall, capture, expire;
  logic [CNT_W-1:0] cap_high, cap_low;

  cm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sig_async (sig_in),
    .rise      (rise),
    .fall      (fall)
  );

  cm_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .fall     (fall),
    .limit    (timeout_limit),
    .capture  (capture),
    .cap_high (cap_high),
    .cap_low  (cap_low),
    .expire   (expire)
  );

  // Staging buffer: holds one complete cycle while the quotients form.
  logic [CNT_W-1:0] stg_high, stg_low, stg_per;
  logic             pending, go, accept;
  logic [CNT_W:0]   cap_sum;
  logic [CNT_W-1:0] cap_per;

  assign cap_sum = {1'b0, cap_high} + {1'b0, cap_low};
  assign cap_per = cap_sum[CNT_W] ? '1 : cap_sum[CNT_W-1:0];

  logic [DIV_W-1:0] dvd [LANES];
  logic [DIV_W-1:0] quo [LANES];
  logic [DIV_W-1:0] dvs;
  logic [LANES-1:0] busy, done;

  assign dvd[0] = DIV_W'(CLK_HZ);
  assign dvd[1] = DIV_W'(stg_high) * DIV_W'(DUTY_FULL);
  assign dvs    = DIV_W'(stg_per);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cm_divider #(.W(DIV_W)) u_div (
      .clk      (clk),
      .rst      (rst),
      .start    (go),
      .dividend (dvd[g]),
      .divisor  (dvs),
      .busy     (busy[g]),
      .done     (done[g]),
      .quotient (quo[g])
    );
  end

  assign accept = capture && !pending && !(|busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_high      <= '0;
      stg_low       <= '0;
      stg_per       <= '0;
      pending       <= 1'b0;
      go            <= 1'b0;
      high_cycles   <= '0;
      low_cycles    <= '0;
      period_cycles <= '0;
      freq_hz       <= '0;
      duty_pct      <= '0;
      result_valid  <= 1'b0;
      no_signal     <= 1'b0;
    end else begin
      go           <= 1'b0;
      result_valid <= 1'b0;
      if (expire) begin
        pending       <= 1'b0;
        high_cycles   <= '0;
        low_cycles    <= '0;
        period_cycles <= '0;
        freq_hz       <= '0;
        duty_pct      <= '0;
        no_signal     <= 1'b1;
      end else if (pending && (&done)) begin
        pending       <= 1'b0;
        high_cycles   <= stg_high;
        low_cycles    <= stg_low;
        period_cycles <= stg_per;
        freq_hz       <= (quo[0] > FREQ_CAP) ? FREQ_CAP[FREQ_W-1:0] : quo[0][FREQ_W-1:0];
        duty_pct      <= (quo[1] > DUTY_CAP) ? DUTY_CAP[DUTY_W-1:0] : quo[1][DUTY_W-1:0];
        result_valid  <= 1'b1;
        no_signal     <= 1'b0;
      end else if (accept) begin
        stg_high <= cap_high;
        stg_low  <= cap_low;
        stg_per  <= cap_per;
        pending  <= 1'b1;
        go       <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cycle_meter_checker.sv
module cycle_meter_checker #(
  parameter int CNT_W  = 32,
  parameter int FREQ_W = 27
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  timeout_limit,
  input logic [CNT_W-1:0]  high_cycles,
  input logic [CNT_W-1:0]  low_cycles,
  input logic [CNT_W-1:0]  period_cycles,
  input logic [FREQ_W-1:0] freq_hz,
  input logic [6:0]        duty_pct,
  input logic              result_valid,
  input logic              no_signal
);

  // R6: the strobe lasts a single cycle
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R6: without a strobe or flag the published set does not move
  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    (!result_valid && !no_signal) |-> ($stable(high_cycles) && $stable(low_cycles) &&
      $stable(period_cycles) && $stable(freq_hz) && $stable(duty_pct)));

  // R5: duty never exceeds one hundred percent
  p_duty_bound_r5: assert property (@(posedge clk) disable iff (rst)
    duty_pct <= 7'd100);

  // R3 / R7: period is the saturating sum, so it never falls below the high count
  p_period_covers_high_r3: assert property (@(posedge clk) disable iff (rst)
    period_cycles >= high_cycles);

  // R8: a freshly raised flag comes with cleared results
  p_flag_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(no_signal) |-> (high_cycles == '0 && low_cycles == '0 &&
      period_cycles == '0 && freq_hz == '0 && duty_pct == '0));

  // R10: a publication and the absence flag never coexist
  p_no_strobe_when_absent_r10: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !no_signal);

  // R9: a zero limit never raises the flag
  p_disabled_timeout_r9: assert property (@(posedge clk) disable iff (rst)
    (timeout_limit == '0) |=> !$rose(no_signal));

endmodule

bind cycle_meter cycle_meter_checker #(.CNT_W(CNT_W), .FREQ_W(FREQ_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .timeout_limit (timeout_limit),
  .high_cycles   (high_cycles),
  .low_cycles    (low_cycles),
  .period_cycles (period_cycles),
  .freq_hz       (freq_hz),
  .duty_pct      (duty_pct),
  .result_valid  (result_valid),
  .no_signal     (no_signal)
);

// File: tb/tb_cycle_meter.sv
module tb_cycle_meter;

  localparam int CLK_HZ = 125_000_000;
  localparam int FW     = $clog2(CLK_HZ + 1);
  localparam int SAT_W  = 6;
  localparam int SAT_MX = (1 << SAT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig = 1'b0;
  logic [31:0] tlim = 32'd300;

  logic [31:0] hi, lo, per;
  logic [FW-1:0] frq;
  logic [6:0] duty;
  logic valid, nosig;

  logic [SAT_W-1:0] s_hi, s_lo, s_per;
  logic [FW-1:0] s_frq;
  logic [6:0] s_duty;
  logic s_valid, s_nosig;

  always #4 clk = ~clk;

  cycle_meter #(.CNT_W(32), .CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst(rst), .sig_in(sig), .timeout_limit(tlim),
    .high_cycles(hi), .low_cycles(lo), .period_cycles(per),
    .freq_hz(frq), .duty_pct(duty), .result_valid(valid), .no_signal(nosig));

  cycle_meter #(.CNT_W(SAT_W), .CLK_HZ(CLK_HZ)) dut_sat (
    .clk(clk), .rst(rst), .sig_in(sig), .timeout_limit('0),
    .high_cycles(s_hi), .low_cycles(s_lo), .period_cycles(s_per),
    .freq_hz(s_frq), .duty_pct(s_duty), .result_valid(s_valid), .no_signal(s_nosig));

  int checks = 0;
  int fails  = 0;
  int vcount = 0;
  int gen_mode = 0;   // 0: hold gen_lvl, 1: periodic
  int gen_lvl  = 0;
  int gen_h = 1;
  int gen_l = 1;
  logic prev_valid = 1'b0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Stimulus generator: changes only at falling clock edges.
  initial begin
    int h, l;
    forever begin
      if (gen_mode == 0) begin
        @(negedge clk);
        sig = gen_lvl[0];
      end else begin
        h = gen_h;
        l = gen_l;
        sig = 1'b1;
        repeat (h) @(negedge clk);
        sig = 1'b0;
        repeat (l) @(negedge clk);
      end
    end
  end

  // Strobe and coherence monitor on the main instance.
  always @(negedge clk) begin
    if (!rst) begin
      if (valid && prev_valid) begin
        checks++; fails++;
        $display("FAIL R6: actual strobe 2 cycles expected 1");
      end
      if (valid && nosig) begin
        checks++; fails++;
        $display("FAIL R10: actual strobe with no_signal=1 expected no_signal=0");
      end
      if (valid) begin
        vcount++;
        chk("R7 period equals high+low", per, longint'(hi) + longint'(lo));
      end
    end
    prev_valid = valid;
  end

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog (all): actual run still busy expected completion");
    summary();
    $finish;
  end

  task automatic check_main(input int h, input int l, input string tag);
    int p;
    p = h + l;
    chk({tag, " R2 high"}, hi, h);
    chk({tag, " R2 low"}, lo, l);
    chk({tag, " R3 period"}, per, p);
    chk({tag, " R4 freq"}, frq, CLK_HZ / p);
    chk({tag, " R5 duty"}, duty, (h * 100) / p);
  endtask

  initial begin
    int vals[10] = '{1, 2, 3, 5, 9, 17, 33, 64, 100, 150};
    int v0, p, sh, sl, sp, sd;

    // R1: reset state
    repeat (5) @(negedge clk);
    chk("R1 high", hi, 0);
    chk("R1 freq", frq, 0);
    chk("R1 duty", duty, 0);
    chk("R1 valid", valid, 0);
    chk("R1 no_signal", nosig, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 period after release", per, 0);
    chk("R1 valid after release", valid, 0);

    // R8: quiet input after reset raises the flag only after the limit
    repeat (250) @(negedge clk);
    chk("R8 not yet expired", nosig, 0);
    repeat (70) @(negedge clk);
    chk("R8 expired on quiet input", nosig, 1);

    // R2 R4 R5 R6 R7: sweep of high/low lengths
    gen_mode = 1;
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        gen_h = vals[i];
        gen_l = vals[j];
        p = vals[i] + vals[j];
        v0 = vcount;
        repeat (3 * p + 300) @(negedge clk);
        check_main(vals[i], vals[j], "sweep");
        checks++;
        if (vcount == v0) begin
          fails++;
          $display("FAIL R6: actual 0 strobes expected at least 1");
        end
        if (i == 0 && j == 0) chk("R8 flag cleared by publication", nosig, 0);
      end
    end

    // R3: saturation on the narrow instance
    for (int k = 0; k < 2; k++) begin
      gen_h = (k == 0) ? 100 : 10;
      gen_l = (k == 0) ? 10 : 100;
      repeat (3 * 110 + 300) @(negedge clk);
      sh = (gen_h > SAT_MX) ? SAT_MX : gen_h;
      sl = (gen_l > SAT_MX) ? SAT_MX : gen_l;
      sp = (sh + sl > SAT_MX) ? SAT_MX : sh + sl;
      sd = (sh * 100) / sp;
      if (sd > 100) sd = 100;
      chk("R3 saturated high", s_hi, sh);
      chk("R3 saturated low", s_lo, sl);
      chk("R3 saturated period", s_per, sp);
      chk("R4 freq from saturated period", s_frq, CLK_HZ / sp);
      chk("R5 duty from saturated period", s_duty, sd);
      check_main(gen_h, gen_l, "wide");
    end

    // R8: stuck-high input
    gen_lvl = 1;
    gen_mode = 0;
    repeat (500) @(negedge clk);
    chk("R8 stuck high flag", nosig, 1);
    chk("R8 stuck high zero high", hi, 0);
    chk("R8 stuck high zero freq", frq, 0);
    chk("R8 stuck high zero duty", duty, 0);

    // R9: zero limit disables the timeout
    tlim = 32'd0;
    gen_h = 60;
    gen_l = 60;
    gen_mode = 1;
    repeat (3 * 120 + 300) @(negedge clk);
    check_main(60, 60, "before quiet");
    gen_lvl = 0;
    gen_mode = 0;
    repeat (1500) @(negedge clk);
    chk("R9 flag stays low", nosig, 0);
    chk("R9 high held", hi, 60);
    chk("R9 freq held", frq, CLK_HZ / 120);
    tlim = 32'd300;
    repeat (5) @(negedge clk);
    chk("R8 expiry after re-enable", nosig, 1);
    chk("R8 zero after re-enable", per, 0);

    // R10: sweep the limit across the divider latency
    for (int lim = 25; lim <= 56; lim++) begin
      tlim = lim;
      gen_lvl = 1; repeat (3) @(negedge clk);
      gen_lvl = 0; repeat (3) @(negedge clk);
      gen_lvl = 1; repeat (3) @(negedge clk);
      gen_lvl = 0; repeat (lim + 100) @(negedge clk);
      chk("R10 final flag", nosig, 1);
      chk("R10 final high zero", hi, 0);
      chk("R10 final freq zero", frq, 0);
    end

    summary();
    $finish;
  end

endmodule